// File: doc/BRIEF.md
# Sixth-Order CIC Decimator with Droop Equalizer

This block is the front stage of a decimation chain for an oversampled sigma-delta audio converter. It accepts signed multibit samples from the modulator, qualified by a valid strobe, and lowers the sample rate by sixteen. The rate reduction uses a sixth-order cascaded integrator-comb filter. The integrators run once per accepted input and the comb section runs once per output. The filters that complete the overall division by 128 sit after this block.

A three-tap symmetric equalizer follows the comb section and runs at the decimated rate. Its taps are -b, 1+2b, -b. The coefficient b is a signed fixed-point value supplied on a port, so the passband tilt can be tuned at run time. The tuning flattens the sinc-shaped roll-off of the CIC and, where needed, the droop of an analogue anti-alias filter ahead of the modulator. The equalized result is rounded, saturated and presented with a one-cycle valid pulse. With the default parameters this gives 768 kHz from a 12.288 MHz modulator stream.

Top module: `cic_droop_decim`

## Requirements
- R1: A synchronous active-high `rst` clears every integrator, comb delay, equalizer tap and the phase counter. On the cycle after reset, `out_valid` is 0 and `out_sample` is 0. Outputs after reset are computed as if all earlier inputs were zero.
- R2: Inputs are counted from reset. `out_valid` rises on the clock edge after the edge that accepts the 16th, 32nd, 48th… input, and it stays high for exactly one cycle.
- R3: An input is accepted only on an edge where `in_valid` is 1. Cycles with `in_valid` at 0 leave the outputs and the filter state as they would be without those cycles.
- R4: The CIC result y[m] is the sum over k = 0..90 of h[k]·x[n−k]. Here n is the index of the accepted input that completes output m, and h holds the coefficients of ((1−z^-16)/(1−z^-1))^6. The internal width is IN_W+24 = 28 bits with wraparound arithmetic, so a full-scale DC input of +7 or −8 gives y = 7·2^24 or −8·2^24 exactly.
- R5: The equalizer computes a = (2^14+2b)·y[m−1] − b·(y[m]+y[m−2]), where b is `beta` read as signed Q2.14. It then outputs floor((a + 2^17) / 2^18), which combines the Q2.14 scaling with division by 16 (round half up).
- R6: The rounded result is clamped to the signed 24-bit range [−8388608, 8388607].
- R7: The `beta` value used for output m is the one present on the edge that accepts that output's 16th input. Values of `beta` on any other cycle have no effect.
- R8: `out_sample` holds its value on every cycle where `out_valid` is 0.
- R9: With `beta` = 0, each output equals y[m−1]/16 rounded, so a DC input x settles to x·2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | IN_W (4) | Signed modulator sample |
| beta | input | BETA_W (16) | Signed Q2.14 equalizer coefficient |
| out_valid | output | 1 | One-cycle output strobe |
| out_sample | output | OUT_W (24) | Rounded, saturated equalized sample |

## Verification
Full-scale DC inputs of both signs check that the 28-bit accumulators reproduce the exact gain of 2^24. A design one bit too narrow, or one that saturated its integrators, would settle to a wrong value. A high-coefficient square wave drives the equalizer into its clamp; a missing saturation would wrap to the opposite sign. Random gaps in the input strobe check that an idle cycle neither advances the phase counter nor shifts the integrators, which would move or corrupt the output pulses. A coefficient that changes on every cycle exposes a design that reads `beta` live rather than at the output boundary, because the results would then depend on when inside the frame the value was read.

// File: rtl/cic_eq_pkg.sv
package cic_eq_pkg;
  localparam int DEF_IN_W      = 4;
  localparam int DEF_RATE      = 16;
  localparam int DEF_ORDER     = 6;
  localparam int DEF_BETA_W    = 16;
  localparam int DEF_BETA_FRAC = 14;
  localparam int DEF_OUT_W     = 24;
endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int ORDER = 6,
  parameter int W     = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] sum_next
);
  logic signed [W-1:0] acc_q [ORDER];
  logic signed [W-1:0] acc_d [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign acc_d[k] = acc_q[k] + x;
    end else begin : g_tail
      assign acc_d[k] = acc_q[k] + acc_d[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst)     acc_q[k] <= '0;
      else if (en) acc_q[k] <= acc_d[k];
    end
  end

  assign sum_next = acc_d[ORDER-1];
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int ORDER = 6,
  parameter int W     = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic                y_valid,
  output logic signed [W-1:0] y
);
  logic signed [W-1:0] dly_q [ORDER];
  logic signed [W-1:0] diff  [ORDER+1];

  assign diff[0] = x;
  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    assign diff[k+1] = diff[k] - dly_q[k];
    always_ff @(posedge clk) begin
      if (rst)     dly_q[k] <= '0;
      else if (en) dly_q[k] <= diff[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_valid <= 1'b0;
      y       <= '0;
    end else begin
      y_valid <= en;
      if (en) y <= diff[ORDER];
    end
  end
endmodule

// File: rtl/droop_eq.sv
module droop_eq #(
  parameter int W      = 28,
  parameter int BETA_W = 16,
  parameter int FRAC   = 14,
  parameter int OUT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [W-1:0]      y,
  input  logic signed [BETA_W-1:0] beta,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_sample
);
  localparam int CW    = BETA_W + 2;
  localparam int PW    = W + CW + 2;
  localparam int SHIFT = FRAC + (W - OUT_W);
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(64'sd1 <<< (OUT_W - 1));

  logic signed [W-1:0]  t1_q, t2_q;
  logic signed [CW-1:0] side_c, ctr_c;
  logic signed [PW-1:0] acc_c, scaled_c;
  logic signed [OUT_W-1:0] sat_c;

  assign side_c = CW'(beta);
  assign ctr_c  = (CW'(1) <<< FRAC) + (side_c <<< 1);

  always_comb begin
    acc_c    = PW'(t1_q) * PW'(ctr_c) - PW'(side_c) * (PW'(y) + PW'(t2_q));
    scaled_c = (acc_c + HALF) >>> SHIFT;
    if (scaled_c > MAXV)      sat_c = MAXV[OUT_W-1:0];
    else if (scaled_c < MINV) sat_c = MINV[OUT_W-1:0];
    else                      sat_c = scaled_c[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t1_q       <= '0;
      t2_q       <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        t1_q       <= y;
        t2_q       <= t1_q;
        out_sample <= sat_c;
      end
    end
  end
endmodule

// File: rtl/cic_droop_decim.sv
module cic_droop_decim
  import cic_eq_pkg::*;
#(
  parameter int IN_W      = DEF_IN_W,
  parameter int RATE      = DEF_RATE,
  parameter int ORDER     = DEF_ORDER,
  parameter int BETA_W    = DEF_BETA_W,
  parameter int BETA_FRAC = DEF_BETA_FRAC,
  parameter int OUT_W     = DEF_OUT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_sample,
  input  logic signed [BETA_W-1:0] beta,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_sample
);
  localparam int CNT_W = $clog2(RATE);
  localparam int ACC_W = IN_W + ORDER * CNT_W;

  logic [CNT_W-1:0]         phase_q;
  logic                     tick;
  logic signed [BETA_W-1:0] beta_act_q;
  logic signed [ACC_W-1:0]  integ_sum;
  logic signed [ACC_W-1:0]  cic_y;
  logic                     cic_valid;

  assign tick = in_valid && (phase_q == CNT_W'(RATE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= '0;
      beta_act_q <= '0;
    end else begin
      if (in_valid) phase_q <= phase_q + 1'b1;
      if (tick)     beta_act_q <= beta;
    end
  end

  cic_integ #(.ORDER(ORDER), .W(ACC_W)) integ_i (
    .clk(clk), .rst(rst), .en(in_valid),
    .x(ACC_W'(in_sample)), .sum_next(integ_sum)
  );

  cic_comb #(.ORDER(ORDER), .W(ACC_W)) comb_i (
    .clk(clk), .rst(rst), .en(tick),
    .x(integ_sum), .y_valid(cic_valid), .y(cic_y)
  );

  droop_eq #(.W(ACC_W), .BETA_W(BETA_W), .FRAC(BETA_FRAC), .OUT_W(OUT_W)) eq_i (
    .clk(clk), .rst(rst), .in_valid(cic_valid), .y(cic_y), .beta(beta_act_q),
    .out_valid(out_valid), .out_sample(out_sample)
  );
endmodule

// File: rtl/cic_droop_decim_chk.sv
module cic_droop_decim_chk #(
  parameter int RATE  = 16,
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_sample
);
  localparam int CW = $clog2(RATE);
  logic [CW-1:0] seen_q;
  logic          last_in;

  assign last_in = in_valid && (seen_q == CW'(RATE - 1));

  always_ff @(posedge clk) begin
    if (rst)           seen_q <= '0;
    else if (in_valid) seen_q <= seen_q + 1'b1;
  end

  // R2: every 16th accepted input produces a pulse
  a_r2_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    last_in |-> ##2 out_valid);

  // R2: no pulse without a completed frame
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(last_in, 2));

  // R2: pulse lasts one cycle
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: output held between pulses
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_sample));

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_sample == '0));
endmodule

bind cic_droop_decim cic_droop_decim_chk #(.RATE(RATE), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/cic_droop_decim_tb.sv
module cic_droop_decim_tb_top;
  localparam int NH = 91;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [3:0]  in_sample = '0;
  logic signed [15:0] beta = '0;
  logic out_valid;
  logic signed [23:0] out_sample;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";
  bit done = 1'b0;

  longint h [NH];
  longint xs [NH];
  longint y1 = 0, y2 = 0;
  int cnt = 0;
  int edge_n = 0;
  bit pend = 1'b0;
  int pend_edge = 0;
  longint pend_data = 0;
  longint last_out = 0;
  int sat_hits = 0;
  int model_outs = 0;
  int dut_outs = 0;

  always #10 clk = ~clk;

  cic_droop_decim dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .beta(beta), .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  initial begin
    longint tmp [NH];
    for (int i = 0; i < NH; i++) h[i] = 0;
    h[0] = 1;
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < NH; i++) begin
        tmp[i] = 0;
        for (int j = 0; j < 16; j++) if (i - j >= 0) tmp[i] += h[i-j];
      end
      for (int i = 0; i < NH; i++) h[i] = tmp[i];
    end
  end

  // Behavioural reference, updated on each edge with the inputs it sees
  always @(posedge clk) begin
    edge_n++;
    if (rst) begin
      for (int i = 0; i < NH; i++) xs[i] = 0;
      y1 = 0; y2 = 0; cnt = 0; pend = 1'b0; last_out = 0;
    end else if (in_valid) begin
      for (int i = NH - 1; i > 0; i--) xs[i] = xs[i-1];
      xs[0] = longint'(in_sample);
      if (cnt == 15) begin
        longint y, b, a, r;
        y = 0;
        for (int i = 0; i < NH; i++) y += h[i] * xs[i];
        b = longint'(beta);
        a = (16384 + 2 * b) * y1 - b * (y + y2);
        r = (a + 131072) >>> 18;
        if (r > 8388607) begin r = 8388607; sat_hits++; end
        else if (r < -8388608) begin r = -8388608; sat_hits++; end
        y2 = y1; y1 = y;
        pend = 1'b1; pend_edge = edge_n + 1; pend_data = r;
        model_outs++;
        cnt = 0;
      end else cnt++;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit ev;
      ev = pend && (pend_edge == edge_n);
      if (out_valid) dut_outs++;
      check(out_valid == ev, "R2 valid", longint'(out_valid), longint'(ev));
      if (ev) begin
        pend = 1'b0;
        last_out = pend_data;
        check(longint'(out_sample) == pend_data, tag, longint'(out_sample), pend_data);
      end else if (!out_valid) begin
        check(longint'(out_sample) == last_out, "R8 hold", longint'(out_sample), last_out);
      end
    end
  end

  task automatic feed(input int n, input int mode, input int gap_pct, input bit beta_jitter);
    int k = 0;
    while (k < n) begin
      @(posedge clk); #1;
      if (beta_jitter) beta = 16'($urandom);
      if (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        in_sample = 4'($urandom);
      end else begin
        in_valid = 1'b1;
        case (mode)
          0: in_sample = 4'sd7;
          1: in_sample = -4'sd8;
          2: in_sample = 4'($urandom);
          default: in_sample = ((k / 32) % 2 == 1) ? 4'sd7 : -4'sd8;
        endcase
        k++;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
    check(out_sample == 0, "R1 reset data", longint'(out_sample), 0);

    tag = "R9 beta zero";
    beta = 16'sd0;
    feed(208, 0, 0, 1'b0);
    idle(3);
    check(longint'(out_sample) == 7340032, "R4 positive DC gain", longint'(out_sample), 7340032);

    feed(208, 1, 0, 1'b0);
    idle(3);
    check(longint'(out_sample) == -8388608, "R4 negative DC gain", longint'(out_sample), -8388608);

    tag = "R5 equalizer";
    beta = 16'sd3277;
    feed(400, 2, 0, 1'b0);
    beta = -16'sd20000;
    feed(400, 2, 0, 1'b0);

    tag = "R3 gaps";
    beta = 16'sd6000;
    feed(800, 2, 50, 1'b0);

    tag = "R7 beta boundary";
    feed(480, 2, 0, 1'b1);
    feed(320, 2, 30, 1'b1);

    tag = "R6 saturation";
    beta = 16'sd32767;
    feed(640, 3, 0, 1'b0);
    idle(3);
    check(sat_hits > 0, "R6 clamp reached", sat_hits, 1);

    idle(4);
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 mid-run reset valid", longint'(out_valid), 0);
    check(out_sample == 0, "R1 mid-run reset data", longint'(out_sample), 0);
    tag = "R1 post-reset history";
    beta = 16'sd0;
    feed(64, 0, 0, 1'b0);
    idle(4);

    check(dut_outs == model_outs, "R2 output count", dut_outs, model_outs);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", edge_n, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule